// File: doc/BRIEF.md
# Dual-Issue Instruction Queue Dispatcher

This block sits between instruction fetch and the execution resources. Each clock the fetch side may offer one 64-bit pair of opaque 32-bit instruction words, each tagged with a branch flag. Accepted words are kept in a small collapsing queue in program order. Occupied slots always fill the queue from slot 0 upward with no holes.

Every clock the queue offers three things. The oldest branch it holds goes to a single branch port, which always accepts. Up to two of the oldest non-branch entries go to two execution ports, each gated by its own ready input. Non-branch words never leave out of order among themselves. Whatever remains is closed up toward slot 0 in the same clock that the new pair is appended behind it.

A stall output tells fetch when a pair cannot be taken. A flush input, used on a redirect, discards everything the block holds.

Top module: `iq_dispatch`

## Requirements
- R1: While reset is asserted and after it is released with no fetch, the queue is empty, all three issue valids are low and fetch_stall is low.
- R2: A fetch pair is accepted when fetch_valid is high, fetch_stall is low and flush is low. fetch_data[31:0] is the older word and its branch flag is fetch_is_br[0]; fetch_data[63:32] is the younger word and its flag is fetch_is_br[1]. An accepted pair is placed above all surviving entries, older below younger. It can issue from the next clock on.
- R3: Each clock, if the queue holds a branch, the one nearest slot 0 is presented on the branch port with br_valid high and removed at the clock edge. Younger branches wait.
- R4: With both execution ports ready, the oldest queued non-branch issues on port 0 and the second-oldest on port 1.
- R5: With exactly one execution port ready, only the oldest non-branch issues, on the port that is ready. With no port ready, no non-branch issues. An execution valid is never high while its ready is low.
- R6: fetch_stall is high when the occupancy, minus the number of entries issuing this clock (ignoring flush), exceeds DEPTH-2. A pair offered while fetch_stall is high is not taken.
- R7: While flush is high, all issue valids are low, the offered pair is dropped, and the queue is empty after the clock edge.
- R8: Entries that are not issued keep their relative program order and are packed down to slot 0 in the same clock. No word is lost, duplicated or reordered among non-branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all held and offered instructions |
| fetch_valid | input | 1 | A fetch pair is offered |
| fetch_data | input | 64 | Two instruction words, older in the low half |
| fetch_is_br | input | 2 | Branch flag per word, bit 0 for the low half |
| fetch_stall | output | 1 | The offered pair cannot be accepted this clock |
| br_valid | output | 1 | A branch is issued on the branch port |
| br_instr | output | 32 | Issued branch word |
| ex0_ready | input | 1 | Execution port 0 can take a word |
| ex0_valid | output | 1 | A word is issued on port 0 |
| ex0_instr | output | 32 | Word issued on port 0 |
| ex1_ready | input | 1 | Execution port 1 can take a word |
| ex1_valid | output | 1 | A word is issued on port 1 |
| ex1_instr | output | 32 | Word issued on port 1 |

## Verification
Every accepted word carries a unique serial number, so any corruption of the queue surfaces as a wrong word on an issue port. A hole left by compaction, a misplaced append or a stale entry left by a flush all show up this way. The error appears on the first clock in which that word would be the oldest of its kind, usually within one or two clocks. A wrong occupancy shows up at once as a fetch_stall mismatch. It also shows up later, as a word that issues with no expected counterpart or as a word missing when one is expected.

// File: rtl/iq_pkg.sv
package iq_pkg;

  localparam int INSTR_W = 32;

  typedef struct packed {
    logic               vld;
    logic               br;
    logic [INSTR_W-1:0] word;
  } iq_entry_t;

  // fetch must wait when fewer than two slots remain after this cycle's issue
  function automatic logic iq_blocked(input int unsigned occ,
                                      input int unsigned leaving,
                                      input int unsigned depth);
    return (occ - leaving) + 2 > depth;
  endfunction

  function automatic int unsigned iq_leaving(input logic a, input logic b,
                                             input logic c);
    return int'(a) + int'(b) + int'(c);
  endfunction

endpackage

// File: rtl/iq_pick.sv
module iq_pick #(
  parameter int DEPTH = 6,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] vld,
  input  logic [DEPTH-1:0] is_br,
  output logic             br_hit,
  output logic [IDX_W-1:0] br_idx,
  output logic             nb0_hit,
  output logic [IDX_W-1:0] nb0_idx,
  output logic             nb1_hit,
  output logic [IDX_W-1:0] nb1_idx
);

  // scan from slot 0 (oldest) upward
  always_comb begin
    br_hit  = 1'b0;
    br_idx  = '0;
    nb0_hit = 1'b0;
    nb0_idx = '0;
    nb1_hit = 1'b0;
    nb1_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i]) begin
        if (is_br[i]) begin
          if (!br_hit) begin
            br_hit = 1'b1;
            br_idx = IDX_W'(i);
          end
        end else if (!nb0_hit) begin
          nb0_hit = 1'b1;
          nb0_idx = IDX_W'(i);
        end else if (!nb1_hit) begin
          nb1_hit = 1'b1;
          nb1_idx = IDX_W'(i);
        end
      end
    end
  end

endmodule

// File: rtl/iq_compact.sv
module iq_compact
  import iq_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int POS_W = $clog2(DEPTH + 2)
) (
  input  iq_entry_t [DEPTH-1:0] cur,
  input  logic [DEPTH-1:0]      keep,
  input  logic                  push,
  input  iq_entry_t             new_old,
  input  iq_entry_t             new_young,
  output iq_entry_t [DEPTH-1:0] nxt
);

  logic [POS_W-1:0] pos;

  always_comb begin
    nxt = '0;
    pos = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cur[i].vld && keep[i]) begin
        nxt[pos] = cur[i];
        pos      = pos + POS_W'(1);
      end
    end
    if (push) begin
      if (pos < POS_W'(DEPTH))
        nxt[pos] = new_old;
      if (pos + POS_W'(1) < POS_W'(DEPTH))
        nxt[pos + POS_W'(1)] = new_young;
    end
  end

endmodule

// File: rtl/iq_dispatch.sv
module iq_dispatch
  import iq_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 fetch_valid,
  input  logic [2*INSTR_W-1:0] fetch_data,
  input  logic [1:0]           fetch_is_br,
  output logic                 fetch_stall,
  output logic                 br_valid,
  output logic [INSTR_W-1:0]   br_instr,
  input  logic                 ex0_ready,
  output logic                 ex0_valid,
  output logic [INSTR_W-1:0]   ex0_instr,
  input  logic                 ex1_ready,
  output logic                 ex1_valid,
  output logic [INSTR_W-1:0]   ex1_instr
);

  iq_entry_t [DEPTH-1:0] q, q_nxt;
  logic [DEPTH-1:0]      q_vld, q_br, remove;
  logic [CNT_W-1:0]      occ;
  logic                  br_hit, nb0_hit, nb1_hit;
  logic [IDX_W-1:0]      br_idx, nb0_idx, nb1_idx;
  logic                  take_br, take0, take1, fetch_take;
  iq_entry_t             in_old, in_young;

  for (genvar g = 0; g < DEPTH; g++) begin : g_flags
    assign q_vld[g] = q[g].vld;
    assign q_br[g]  = q[g].br;
  end

  assign occ = CNT_W'($countones(q_vld));

  iq_pick #(.DEPTH(DEPTH)) pick_i (
    .vld(q_vld), .is_br(q_br),
    .br_hit(br_hit), .br_idx(br_idx),
    .nb0_hit(nb0_hit), .nb0_idx(nb0_idx),
    .nb1_hit(nb1_hit), .nb1_idx(nb1_idx)
  );

  // issue decisions before flush gating
  assign take_br = br_hit;
  assign take0   = nb0_hit & (ex0_ready | ex1_ready);
  assign take1   = nb1_hit & ex0_ready & ex1_ready;

  assign br_valid  = take_br & ~flush;
  assign br_instr  = q[br_idx].word;
  assign ex0_valid = take0 & ex0_ready & ~flush;
  assign ex0_instr = q[nb0_idx].word;
  assign ex1_valid = (take1 | (take0 & ~ex0_ready)) & ~flush;
  assign ex1_instr = take1 ? q[nb1_idx].word : q[nb0_idx].word;

  assign fetch_stall = iq_blocked(int'(occ), iq_leaving(take_br, take0, take1), DEPTH);
  assign fetch_take  = fetch_valid & ~fetch_stall & ~flush;

  always_comb begin
    remove = '0;
    if (take_br) remove = remove | (DEPTH'(1) << br_idx);
    if (take0)   remove = remove | (DEPTH'(1) << nb0_idx);
    if (take1)   remove = remove | (DEPTH'(1) << nb1_idx);
  end

  assign in_old   = '{vld: 1'b1, br: fetch_is_br[0], word: fetch_data[INSTR_W-1:0]};
  assign in_young = '{vld: 1'b1, br: fetch_is_br[1], word: fetch_data[2*INSTR_W-1:INSTR_W]};

  iq_compact #(.DEPTH(DEPTH)) compact_i (
    .cur(q), .keep(~remove), .push(fetch_take),
    .new_old(in_old), .new_young(in_young), .nxt(q_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (flush) q <= '0;
    else            q <= q_nxt;
  end

  // R8: occupied slots are contiguous from slot 0
  a_r8_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (q_vld & (q_vld + DEPTH'(1))) == '0);

  // R5: no issue to a port that is not ready
  a_r5_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (ex0_valid -> ex0_ready) && (ex1_valid -> ex1_ready));

  // R4: port 1 never carries a word while a ready port 0 sits idle
  a_r4_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (ex1_valid && ex0_ready) |-> ex0_valid);

  // R7: flush leaves an empty queue
  a_r7_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ == '0));

  // R6: an accepted pair always finds two slots
  a_r6_accept_room: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_stall && !flush) |=> (occ >= CNT_W'(2)));

  // R3: a queued branch is always offered
  a_r3_branch_offer: assert property (@(posedge clk) disable iff (!rst_n)
    ((q_vld & q_br) != '0 && !flush) |-> br_valid);

endmodule

// File: tb/iq_dispatch_tb_top.sv
module iq_dispatch_tb_top;

  localparam int DEPTH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [63:0] fetch_data = '0;
  logic [1:0]  fetch_is_br = '0;
  logic        ex0_ready = 1'b0, ex1_ready = 1'b0;
  logic        fetch_stall, br_valid, ex0_valid, ex1_valid;
  logic [31:0] br_instr, ex0_instr, ex1_instr;

  always #4 clk = ~clk;

  iq_dispatch #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fetch_valid(fetch_valid), .fetch_data(fetch_data), .fetch_is_br(fetch_is_br),
    .fetch_stall(fetch_stall),
    .br_valid(br_valid), .br_instr(br_instr),
    .ex0_ready(ex0_ready), .ex0_valid(ex0_valid), .ex0_instr(ex0_instr),
    .ex1_ready(ex1_ready), .ex1_valid(ex1_valid), .ex1_instr(ex1_instr)
  );

  typedef struct { logic [31:0] w; bit br; } m_t;
  m_t mq[$];

  int errors = 0, checks = 0;
  bit done = 1'b0;
  int unsigned serial = 1;
  logic [31:0] p_old, p_young;
  logic [1:0]  p_br;
  bit directed = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic new_pair(input int br_pct);
    p_old   = serial;
    p_young = serial + 1;
    serial  += 2;
    p_br[0] = ($urandom_range(99) < br_pct);
    p_br[1] = ($urandom_range(99) < br_pct);
  endtask

  // one clock: drive, compare against the model, advance the model
  task automatic step(input bit fv, input bit r0, input bit r1, input bit fl);
    int bi, n0, n1, leave;
    bit t0, t1, tb, e_stall, e0v, e1v, ebv;
    logic [31:0] e0w, e1w, ebw;
    string exreq;
    m_t nq[$];
    @(negedge clk);
    fetch_valid = fv; fetch_data = {p_young, p_old}; fetch_is_br = p_br;
    ex0_ready = r0; ex1_ready = r1; flush = fl;
    #1;
    bi = -1; n0 = -1; n1 = -1;
    for (int i = 0; i < mq.size(); i++) begin
      if (mq[i].br) begin if (bi < 0) bi = i; end
      else if (n0 < 0) n0 = i;
      else if (n1 < 0) n1 = i;
    end
    tb = (bi >= 0);
    t0 = (n0 >= 0) && (r0 || r1);
    t1 = (n1 >= 0) && r0 && r1;
    leave = int'(tb) + int'(t0) + int'(t1);
    e_stall = (mq.size() - leave) > DEPTH - 2;
    ebv = tb && !fl;
    e0v = t0 && r0 && !fl;
    e1v = ((t1) || (t0 && !r0)) && !fl;
    ebw = tb ? mq[bi].w : 32'h0;
    e0w = (n0 >= 0) ? mq[n0].w : 32'h0;
    e1w = t1 ? mq[n1].w : e0w;
    exreq = fl ? "R7" : directed ? "R2" : (r0 && r1) ? "R4" : "R5";
    chk("R6 fetch_stall", {31'b0, fetch_stall}, {31'b0, e_stall});
    chk(fl ? "R7 br_valid" : "R3 br_valid", {31'b0, br_valid}, {31'b0, ebv});
    if (ebv) chk("R3 br_instr", br_instr, ebw);
    chk({exreq, " ex0_valid"}, {31'b0, ex0_valid}, {31'b0, e0v});
    if (e0v) chk(directed ? "R2 ex0_instr" : "R8 ex0_instr", ex0_instr, e0w);
    chk({exreq, " ex1_valid"}, {31'b0, ex1_valid}, {31'b0, e1v});
    if (e1v) chk(directed ? "R2 ex1_instr" : "R8 ex1_instr", ex1_instr, e1w);
    if (fl) begin
      mq.delete();
      new_pair(30);
    end else begin
      for (int i = 0; i < mq.size(); i++)
        if (!((tb && i == bi) || (t0 && i == n0) || (t1 && i == n1))) nq.push_back(mq[i]);
      mq = nq;
      if (fv && !e_stall) begin
        mq.push_back('{w: p_old, br: p_br[0]});
        mq.push_back('{w: p_young, br: p_br[1]});
        new_pair(30);
      end
    end
  endtask

  task automatic phase(input int n, input int fv_pct, input int rdy_pct,
                       input int fl_pct);
    for (int k = 0; k < n; k++)
      step($urandom_range(99) < fv_pct, $urandom_range(99) < rdy_pct,
           $urandom_range(99) < rdy_pct, $urandom_range(99) < fl_pct);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(64'd8 * 64'd200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    new_pair(0);
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs idle in reset
    chk("R1 stall in reset", {31'b0, fetch_stall}, 32'h0);
    chk("R1 valids in reset", {29'b0, br_valid, ex0_valid, ex1_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 stall after reset", {31'b0, fetch_stall}, 32'h0);
    chk("R1 valids after reset", {29'b0, br_valid, ex0_valid, ex1_valid}, 32'h0);
    // R2: one non-branch pair, then both ports ready: older on port 0
    directed = 1'b1;
    step(1, 0, 0, 0);
    step(0, 1, 1, 0);
    step(0, 1, 1, 0);
    directed = 1'b0;
    // fill to stall with no ready port, then drain (R6)
    for (int k = 0; k < 6; k++) step(1, 0, 0, 0);
    for (int k = 0; k < 6; k++) step(0, 0, 1, 0);
    for (int k = 0; k < 6; k++) step(0, 1, 0, 0);
    // flush with a full queue (R7)
    for (int k = 0; k < 4; k++) step(1, 0, 0, 0);
    step(1, 1, 1, 1);
    step(0, 1, 1, 0);
    phase(600, 90, 90, 0);
    phase(600, 80, 50, 0);
    phase(600, 95, 20, 2);
    phase(600, 60, 70, 5);
    finish_run();
  end

endmodule